// File: doc/BRIEF.md
# MSI Child Cache Coherence Controller

This block is the coherence agent that sits beside one cache in a tree of inclusive caches. For every line it tracks it keeps a coherence level (Invalid, Shared or Modified), the line data and a field that records which level it has already asked its parent for. A processor load is served at once when the line is Shared or Modified. A store is served at once only when the line is Modified. In every other case the controller sends the parent an upgrade request that names the level it needs. The processor holds its request until the upgrade response arrives and raises the line.

The parent talks to the controller over one ordered channel. That channel carries both upgrade responses and downgrade requests, and the controller consumes it strictly from its head. The controller answers real downgrades on an ordered response channel. Upgrade requests leave on a separate channel whose delivery order does not matter. A voluntary-evict input lets the surrounding cache lower a line on its own, and the parent is told through the same downgrade response channel.

Because an eviction can already have lowered a line, the parent's picture may lag behind. A downgrade request that asks for a level the line is already at or below is therefore popped and discarded without any reply.

Top module: `msi_child_ctrl`

## Requirements
- R1: After reset every line is Invalid with no upgrade pending, and with no inputs active no output valid, pop or done signal is high. Level encoding on all ports: 0 = Invalid, 1 = Shared, 2 = Modified.
- R2: A load to a line in Shared or Modified gives rsp_valid in the same cycle, with rsp_tag equal to the request tag and rsp_data equal to the line data.
- R3: A store is served only when the line is Modified. It gives rsp_valid and rsp_tag in the same cycle with rsp_data equal to the written value, and later loads return that value.
- R4: A load to an Invalid line, or a store to a line that is not Modified, gives no response and raises upq_valid with upq_addr equal to the request address and upq_state equal to 1 for a load or 2 for a store.
- R5: Once an upgrade to a given level has been sent for a line, no further upgrade request is raised for that line while the recorded pending level is at or above the level now needed.
- R6: An upgrade response (p2c_is_dn = 0) at the channel head is always popped in that cycle. The line takes p2c_state and p2c_data and its pending field clears, so the held request is served afterwards.
- R7: A downgrade request (p2c_is_dn = 1) to a level strictly below the line's level raises dnr_valid with the target level, the address and the current line data. On the cycle dnr_ready is high the head is popped and the line is lowered at the same clock edge.
- R8: A downgrade request whose target is at or above the line's current level is popped with no downgrade response, and the line is unchanged.
- R9: ev_valid lowers the line at ev_addr to ev_state and sends a downgrade response carrying that level and the line data, and ev_done is high in that cycle. If the line is already at or below ev_state, ev_done is high and no response is sent.
- R10: Each cycle performs at most one action, in this priority: the parent channel head, then eviction, then the processor request. A downgrade whose response is refused (dnr_ready low) is not popped and blocks everything below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_is_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | IDX_W | Line index of the request |
| req_wdata | input | DATA_W | Store data |
| req_tag | input | TAG_W | Request tag |
| rsp_valid | output | 1 | Request served this cycle |
| rsp_tag | output | TAG_W | Tag of the served request |
| rsp_data | output | DATA_W | Load data, or store data for stores |
| upq_valid | output | 1 | Upgrade request offered |
| upq_ready | input | 1 | Upgrade channel accepts |
| upq_addr | output | IDX_W | Line to upgrade |
| upq_state | output | 2 | Level needed |
| p2c_valid | input | 1 | Parent channel head present |
| p2c_is_dn | input | 1 | 1 = downgrade request, 0 = upgrade response |
| p2c_addr | input | IDX_W | Line addressed by the head message |
| p2c_state | input | 2 | Granted or target level |
| p2c_data | input | DATA_W | Line data for upgrade responses |
| p2c_pop | output | 1 | Head consumed this cycle |
| dnr_valid | output | 1 | Downgrade response offered |
| dnr_ready | input | 1 | Downgrade channel accepts |
| dnr_addr | output | IDX_W | Line downgraded |
| dnr_state | output | 2 | New level of the line |
| dnr_data | output | DATA_W | Line data |
| ev_valid | input | 1 | Voluntary downgrade request |
| ev_addr | input | IDX_W | Line to lower |
| ev_state | input | 2 | Level to lower to |
| ev_done | output | 1 | Voluntary downgrade completed this cycle |

## Verification
The main function is driven with loads and stores that hit Invalid, Shared and Modified lines. This separates serving a request from issuing an upgrade, and it shows whether the requested level follows the access kind. Repeated misses while an upgrade is outstanding check that the pending field suppresses duplicates, including the case where a pending Modified upgrade already covers a later load. Downgrade requests are sent both above and at or below the current level, and with the response channel blocked and open, so that a real downgrade, a dropped stale one and a stall can be told apart. Evictions are raised alone, against lines already low enough, and together with parent traffic, which shows the completion signal and the priority order.

// File: rtl/msi_pkg.sv
package msi_pkg;
   typedef enum logic [1:0] {
      LVL_INV = 2'd0,
      LVL_SHR = 2'd1,
      LVL_MOD = 2'd2
   } msi_lvl_t;

   localparam int LVL_W = 2;
endpackage

// File: rtl/msi_line_bank.sv
module msi_line_bank
   import msi_pkg::*;
#(
   parameter int LINES  = 4,
   parameter int DATA_W = 8,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic                     lvl_we,
   input  logic [LVL_W-1:0]         lvl_wv,
   input  logic                     data_we,
   input  logic [DATA_W-1:0]        data_wv,
   input  logic                     pend_we,
   input  logic [LVL_W-1:0]         pend_wv,
   output logic [LVL_W*LINES-1:0]   lvl_flat,
   output logic [LVL_W*LINES-1:0]   pend_flat,
   output logic [DATA_W*LINES-1:0]  data_flat
);
   generate
      for (genvar g = 0; g < LINES; g++) begin : g_line
         logic [LVL_W-1:0]  lvl_q;
         logic [LVL_W-1:0]  pend_q;
         logic [DATA_W-1:0] data_q;
         logic              hit;

         assign hit = (wr_idx == IDX_W'(g));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lvl_q  <= LVL_INV;
               pend_q <= LVL_INV;
               data_q <= '0;
            end else begin
               if (hit && lvl_we)  lvl_q  <= lvl_wv;
               if (hit && pend_we) pend_q <= pend_wv;
               if (hit && data_we) data_q <= data_wv;
            end
         end

         assign lvl_flat[g*LVL_W +: LVL_W]    = lvl_q;
         assign pend_flat[g*LVL_W +: LVL_W]   = pend_q;
         assign data_flat[g*DATA_W +: DATA_W] = data_q;
      end
   endgenerate
endmodule

// File: rtl/msi_line_pick.sv
module msi_line_pick #(
   parameter int LINES = 4,
   parameter int W     = 2,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic [W*LINES-1:0] flat,
   input  logic [IDX_W-1:0]   idx,
   output logic [W-1:0]       val
);
   always_comb begin
      val = '0;
      for (int i = 0; i < LINES; i++) begin
         if (idx == IDX_W'(i)) val = flat[i*W +: W];
      end
   end
endmodule

// File: rtl/msi_perm_check.sv
module msi_perm_check
   import msi_pkg::*;
(
   input  logic [LVL_W-1:0] cur,
   input  logic             is_store,
   output logic             allowed,
   output logic [LVL_W-1:0] need
);
   always_comb begin
      need    = is_store ? LVL_MOD : LVL_SHR;
      allowed = (cur >= need);
   end
endmodule

// File: rtl/msi_action_arb.sv
module msi_action_arb
   import msi_pkg::*;
#(
   parameter int IDX_W  = 2,
   parameter int DATA_W = 8,
   parameter int TAG_W  = 4
) (
   input  logic              req_valid,
   input  logic              req_is_store,
   input  logic [IDX_W-1:0]  req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic              req_allowed,
   input  logic [LVL_W-1:0]  req_need,
   input  logic [LVL_W-1:0]  req_pend,
   input  logic [DATA_W-1:0] req_line,
   input  logic              p2c_valid,
   input  logic              p2c_is_dn,
   input  logic [IDX_W-1:0]  p2c_addr,
   input  logic [LVL_W-1:0]  p2c_state,
   input  logic [DATA_W-1:0] p2c_data,
   input  logic [LVL_W-1:0]  p2c_cur,
   input  logic [DATA_W-1:0] p2c_line,
   input  logic              ev_valid,
   input  logic [IDX_W-1:0]  ev_addr,
   input  logic [LVL_W-1:0]  ev_state,
   input  logic [LVL_W-1:0]  ev_cur,
   input  logic [DATA_W-1:0] ev_line,
   input  logic              upq_ready,
   input  logic              dnr_ready,
   output logic              rsp_valid,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic [DATA_W-1:0] rsp_data,
   output logic              upq_valid,
   output logic [IDX_W-1:0]  upq_addr,
   output logic [LVL_W-1:0]  upq_state,
   output logic              p2c_pop,
   output logic              dnr_valid,
   output logic [IDX_W-1:0]  dnr_addr,
   output logic [LVL_W-1:0]  dnr_state,
   output logic [DATA_W-1:0] dnr_data,
   output logic              ev_done,
   output logic [IDX_W-1:0]  wr_idx,
   output logic              lvl_we,
   output logic [LVL_W-1:0]  lvl_wv,
   output logic              data_we,
   output logic [DATA_W-1:0] data_wv,
   output logic              pend_we,
   output logic [LVL_W-1:0]  pend_wv
);
   always_comb begin
      rsp_valid = 1'b0;
      rsp_tag   = req_tag;
      rsp_data  = req_is_store ? req_wdata : req_line;
      upq_valid = 1'b0;
      upq_addr  = req_addr;
      upq_state = req_need;
      p2c_pop   = 1'b0;
      dnr_valid = 1'b0;
      dnr_addr  = p2c_addr;
      dnr_state = p2c_state;
      dnr_data  = p2c_line;
      ev_done   = 1'b0;
      wr_idx    = req_addr;
      lvl_we    = 1'b0;
      lvl_wv    = p2c_state;
      data_we   = 1'b0;
      data_wv   = req_wdata;
      pend_we   = 1'b0;
      pend_wv   = LVL_INV;

      if (p2c_valid) begin
         wr_idx = p2c_addr;
         if (!p2c_is_dn) begin
            p2c_pop = 1'b1;
            lvl_we  = 1'b1;
            data_we = 1'b1;
            data_wv = p2c_data;
            pend_we = 1'b1;
            pend_wv = LVL_INV;
         end else if (p2c_cur <= p2c_state) begin
            p2c_pop = 1'b1;
         end else begin
            dnr_valid = 1'b1;
            if (dnr_ready) begin
               p2c_pop = 1'b1;
               lvl_we  = 1'b1;
            end
         end
      end else if (ev_valid) begin
         wr_idx    = ev_addr;
         lvl_wv    = ev_state;
         dnr_addr  = ev_addr;
         dnr_state = ev_state;
         dnr_data  = ev_line;
         if (ev_cur <= ev_state) begin
            ev_done = 1'b1;
         end else begin
            dnr_valid = 1'b1;
            if (dnr_ready) begin
               ev_done = 1'b1;
               lvl_we  = 1'b1;
            end
         end
      end else if (req_valid) begin
         if (req_allowed) begin
            rsp_valid = 1'b1;
            data_we   = req_is_store;
         end else if (req_pend < req_need) begin
            upq_valid = 1'b1;
            pend_we   = upq_ready;
            pend_wv   = req_need;
         end
      end
   end
endmodule

// File: rtl/msi_child_ctrl.sv
module msi_child_ctrl
   import msi_pkg::*;
#(
   parameter int LINES  = 4,
   parameter int DATA_W = 8,
   parameter int TAG_W  = 4,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_is_store,
   input  logic [IDX_W-1:0]  req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              rsp_valid,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic [DATA_W-1:0] rsp_data,
   output logic              upq_valid,
   input  logic              upq_ready,
   output logic [IDX_W-1:0]  upq_addr,
   output logic [1:0]        upq_state,
   input  logic              p2c_valid,
   input  logic              p2c_is_dn,
   input  logic [IDX_W-1:0]  p2c_addr,
   input  logic [1:0]        p2c_state,
   input  logic [DATA_W-1:0] p2c_data,
   output logic              p2c_pop,
   output logic              dnr_valid,
   input  logic              dnr_ready,
   output logic [IDX_W-1:0]  dnr_addr,
   output logic [1:0]        dnr_state,
   output logic [DATA_W-1:0] dnr_data,
   input  logic              ev_valid,
   input  logic [IDX_W-1:0]  ev_addr,
   input  logic [1:0]        ev_state,
   output logic              ev_done
);
   generate
      if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
         $error("LINES must be a power of two of at least 2");
      end
      if (DATA_W < 1 || TAG_W < 1) begin : g_bad_width
         $error("DATA_W and TAG_W must be positive");
      end
   endgenerate

   logic [LVL_W*LINES-1:0]  lvl_flat;
   logic [LVL_W*LINES-1:0]  pend_flat;
   logic [DATA_W*LINES-1:0] data_flat;

   logic [IDX_W-1:0]  wr_idx;
   logic              lvl_we, data_we, pend_we;
   logic [LVL_W-1:0]  lvl_wv, pend_wv;
   logic [DATA_W-1:0] data_wv;

   logic [LVL_W-1:0]  req_cur, req_pend, p2c_cur, ev_cur, req_need;
   logic [DATA_W-1:0] req_line, p2c_line, ev_line;
   logic              req_allowed;

   msi_line_bank #(.LINES(LINES), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_idx(wr_idx),
      .lvl_we(lvl_we), .lvl_wv(lvl_wv),
      .data_we(data_we), .data_wv(data_wv),
      .pend_we(pend_we), .pend_wv(pend_wv),
      .lvl_flat(lvl_flat), .pend_flat(pend_flat), .data_flat(data_flat)
   );

   msi_line_pick #(.LINES(LINES), .W(LVL_W))  u_pk_rlvl (.flat(lvl_flat),  .idx(req_addr), .val(req_cur));
   msi_line_pick #(.LINES(LINES), .W(LVL_W))  u_pk_rpnd (.flat(pend_flat), .idx(req_addr), .val(req_pend));
   msi_line_pick #(.LINES(LINES), .W(DATA_W)) u_pk_rdat (.flat(data_flat), .idx(req_addr), .val(req_line));
   msi_line_pick #(.LINES(LINES), .W(LVL_W))  u_pk_plvl (.flat(lvl_flat),  .idx(p2c_addr), .val(p2c_cur));
   msi_line_pick #(.LINES(LINES), .W(DATA_W)) u_pk_pdat (.flat(data_flat), .idx(p2c_addr), .val(p2c_line));
   msi_line_pick #(.LINES(LINES), .W(LVL_W))  u_pk_elvl (.flat(lvl_flat),  .idx(ev_addr),  .val(ev_cur));
   msi_line_pick #(.LINES(LINES), .W(DATA_W)) u_pk_edat (.flat(data_flat), .idx(ev_addr),  .val(ev_line));

   msi_perm_check u_perm (
      .cur(req_cur), .is_store(req_is_store), .allowed(req_allowed), .need(req_need)
   );

   msi_action_arb #(.IDX_W(IDX_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_arb (
      .req_valid(req_valid), .req_is_store(req_is_store), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_tag(req_tag), .req_allowed(req_allowed),
      .req_need(req_need), .req_pend(req_pend), .req_line(req_line),
      .p2c_valid(p2c_valid), .p2c_is_dn(p2c_is_dn), .p2c_addr(p2c_addr),
      .p2c_state(p2c_state), .p2c_data(p2c_data), .p2c_cur(p2c_cur), .p2c_line(p2c_line),
      .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_state(ev_state),
      .ev_cur(ev_cur), .ev_line(ev_line),
      .upq_ready(upq_ready), .dnr_ready(dnr_ready),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
      .upq_valid(upq_valid), .upq_addr(upq_addr), .upq_state(upq_state),
      .p2c_pop(p2c_pop),
      .dnr_valid(dnr_valid), .dnr_addr(dnr_addr), .dnr_state(dnr_state), .dnr_data(dnr_data),
      .ev_done(ev_done),
      .wr_idx(wr_idx), .lvl_we(lvl_we), .lvl_wv(lvl_wv),
      .data_we(data_we), .data_wv(data_wv), .pend_we(pend_we), .pend_wv(pend_wv)
   );
endmodule

// File: rtl/msi_child_chk.sv
module msi_child_chk #(
   parameter int LINES = 4,
   localparam int IDX_W = $clog2(LINES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_is_store,
   input logic               rsp_valid,
   input logic               upq_valid,
   input logic               p2c_valid,
   input logic               p2c_is_dn,
   input logic               p2c_pop,
   input logic [IDX_W-1:0]   p2c_addr,
   input logic [1:0]         p2c_state,
   input logic               dnr_valid,
   input logic               dnr_ready,
   input logic [IDX_W-1:0]   dnr_addr,
   input logic [1:0]         dnr_state,
   input logic               ev_done,
   input logic [1:0]         req_cur,
   input logic [2*LINES-1:0] lvl_flat
);
   function automatic logic [1:0] lvl_at(input logic [2*LINES-1:0] f, input logic [IDX_W-1:0] i);
      lvl_at = f[i*2 +: 2];
   endfunction

   AST_LOAD_PERM: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !req_is_store |-> req_cur != 2'd0); // R2
   AST_STORE_PERM: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && req_is_store |-> req_cur == 2'd2); // R3
   AST_UPQ_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      upq_valid |-> (req_is_store ? req_cur != 2'd2 : req_cur == 2'd0)); // R4
   AST_UPG_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
      p2c_pop && !p2c_is_dn |=> lvl_at(lvl_flat, $past(p2c_addr)) == $past(p2c_state)); // R6
   AST_DN_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
      dnr_valid |-> dnr_state < lvl_at(lvl_flat, dnr_addr)); // R7
   AST_DN_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
      dnr_valid && dnr_ready |=> lvl_at(lvl_flat, $past(dnr_addr)) == $past(dnr_state)); // R7
   AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_valid, p2c_pop, ev_done, upq_valid})); // R10
   AST_DN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      p2c_valid && p2c_is_dn && dnr_valid && !dnr_ready |-> !p2c_pop); // R10
endmodule

bind msi_child_ctrl msi_child_chk #(.LINES(LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_is_store(req_is_store),
   .rsp_valid(rsp_valid), .upq_valid(upq_valid),
   .p2c_valid(p2c_valid), .p2c_is_dn(p2c_is_dn), .p2c_pop(p2c_pop),
   .p2c_addr(p2c_addr), .p2c_state(p2c_state),
   .dnr_valid(dnr_valid), .dnr_ready(dnr_ready), .dnr_addr(dnr_addr), .dnr_state(dnr_state),
   .ev_done(ev_done), .req_cur(req_cur), .lvl_flat(lvl_flat)
);

// File: tb/sim_msi_child_ctrl.sv
`timescale 1ns/1ps
module sim_msi_child_ctrl;
   localparam int CYC = 4;
   localparam int NV  = 18;

   typedef struct packed {
      logic       pv;
      logic       pst;
      logic [1:0] pa;
      logic [7:0] pwd;
      logic [3:0] ptag;
      logic       mv;
      logic       mdn;
      logic [1:0] ma;
      logic [1:0] mst;
      logic [7:0] md;
      logic       drdy;
      logic       e_rsp;
      logic [7:0] e_rdata;
      logic       e_upq;
      logic [1:0] e_upst;
      logic       e_dnr;
      logic [1:0] e_dnst;
      logic [7:0] e_dndata;
      logic       e_pop;
   } vec_t;

   // Levels: 0 Invalid, 1 Shared, 2 Modified
   localparam vec_t VECS [NV] = '{
      '{1,0,1,8'h00,3, 0,0,0,0,8'h00, 1, 0,8'h00, 1,1, 0,0,8'h00, 0}, // 0  R4 load miss
      '{1,0,1,8'h00,3, 0,0,0,0,8'h00, 1, 0,8'h00, 0,0, 0,0,8'h00, 0}, // 1  R5 no repeat
      '{1,0,1,8'h00,3, 1,0,1,1,8'h5A, 1, 0,8'h00, 0,0, 0,0,8'h00, 1}, // 2  R6 R10 upgrade wins
      '{1,0,1,8'h00,3, 0,0,0,0,8'h00, 1, 1,8'h5A, 0,0, 0,0,8'h00, 0}, // 3  R2 load in S
      '{1,1,1,8'h77,9, 0,0,0,0,8'h00, 1, 0,8'h00, 1,2, 0,0,8'h00, 0}, // 4  R4 store in S
      '{0,0,0,8'h00,0, 1,0,1,2,8'h5A, 1, 0,8'h00, 0,0, 0,0,8'h00, 1}, // 5  R6 to M
      '{1,1,1,8'h77,9, 0,0,0,0,8'h00, 1, 1,8'h77, 0,0, 0,0,8'h00, 0}, // 6  R3 store in M
      '{0,0,0,8'h00,0, 1,1,1,1,8'h00, 0, 0,8'h00, 0,0, 1,1,8'h77, 0}, // 7  R10 stall
      '{0,0,0,8'h00,0, 1,1,1,1,8'h00, 1, 0,8'h00, 0,0, 1,1,8'h77, 1}, // 8  R7 M to S
      '{0,0,0,8'h00,0, 1,1,1,1,8'h00, 1, 0,8'h00, 0,0, 0,0,8'h00, 1}, // 9  R8 stale
      '{1,0,1,8'h00,2, 0,0,0,0,8'h00, 1, 1,8'h77, 0,0, 0,0,8'h00, 0}, // 10 R2 R3 data kept
      '{1,1,1,8'h3C,4, 0,0,0,0,8'h00, 1, 0,8'h00, 1,2, 0,0,8'h00, 0}, // 11 R4 store in S
      '{0,0,0,8'h00,0, 1,1,1,0,8'h00, 1, 0,8'h00, 0,0, 1,0,8'h77, 1}, // 12 R7 S to I
      '{0,0,0,8'h00,0, 1,1,1,0,8'h00, 1, 0,8'h00, 0,0, 0,0,8'h00, 1}, // 13 R8 stale at I
      '{1,0,1,8'h00,5, 0,0,0,0,8'h00, 1, 0,8'h00, 0,0, 0,0,8'h00, 0}, // 14 R5 M pending covers load
      '{0,0,0,8'h00,0, 1,0,1,2,8'h11, 1, 0,8'h00, 0,0, 0,0,8'h00, 1}, // 15 R6 I to M
      '{1,1,2,8'hAB,6, 0,0,0,0,8'h00, 1, 0,8'h00, 1,2, 0,0,8'h00, 0}, // 16 R4 other line
      '{1,0,1,8'h00,7, 0,0,0,0,8'h00, 1, 1,8'h11, 0,0, 0,0,8'h00, 0}  // 17 R2 load in M
   };

   logic       clk = 0, rst_n = 0;
   logic       req_valid = 0, req_is_store = 0;
   logic [1:0] req_addr = 0;
   logic [7:0] req_wdata = 0;
   logic [3:0] req_tag = 0;
   logic       upq_ready = 1;
   logic       p2c_valid = 0, p2c_is_dn = 0;
   logic [1:0] p2c_addr = 0, p2c_state = 0;
   logic [7:0] p2c_data = 0;
   logic       dnr_ready = 1;
   logic       ev_valid = 0;
   logic [1:0] ev_addr = 0, ev_state = 0;
   logic       rsp_valid, upq_valid, p2c_pop, dnr_valid, ev_done;
   logic [3:0] rsp_tag;
   logic [7:0] rsp_data, dnr_data;
   logic [1:0] upq_addr, upq_state, dnr_addr, dnr_state;

   int n_chk = 0, n_fail = 0;

   always #(CYC/2) clk = ~clk;

   msi_child_ctrl #(.LINES(4), .DATA_W(8), .TAG_W(4)) u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_is_store(req_is_store), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_tag(req_tag),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
      .upq_valid(upq_valid), .upq_ready(upq_ready), .upq_addr(upq_addr), .upq_state(upq_state),
      .p2c_valid(p2c_valid), .p2c_is_dn(p2c_is_dn), .p2c_addr(p2c_addr),
      .p2c_state(p2c_state), .p2c_data(p2c_data), .p2c_pop(p2c_pop),
      .dnr_valid(dnr_valid), .dnr_ready(dnr_ready), .dnr_addr(dnr_addr),
      .dnr_state(dnr_state), .dnr_data(dnr_data),
      .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_state(ev_state), .ev_done(ev_done)
   );

   task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      req_valid = 0; req_is_store = 0; req_addr = 0; req_wdata = 0; req_tag = 0;
      p2c_valid = 0; p2c_is_dn = 0; p2c_addr = 0; p2c_state = 0; p2c_data = 0;
      ev_valid = 0; ev_addr = 0; ev_state = 0; dnr_ready = 1; upq_ready = 1;
   endtask

   function automatic string row_req(input int i);
      case (i)
         0, 4, 11, 16: row_req = "R4";
         1, 14:        row_req = "R5";
         2:            row_req = "R10/R6";
         5, 15:        row_req = "R6";
         6:            row_req = "R3";
         7:            row_req = "R10";
         8, 12:        row_req = "R7";
         9, 13:        row_req = "R8";
         default:      row_req = "R2";
      endcase
   endfunction

   initial begin
      #(CYC * 20000);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle_inputs();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      // R1: idle outputs after reset
      check({rsp_valid, upq_valid, p2c_pop, dnr_valid, ev_done} == 5'b0, "R1 idle",
            64'({rsp_valid, upq_valid, p2c_pop, dnr_valid, ev_done}), 64'h0);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         logic ok;
         v = VECS[i];
         @(negedge clk);
         idle_inputs();
         req_valid = v.pv; req_is_store = v.pst; req_addr = v.pa; req_wdata = v.pwd; req_tag = v.ptag;
         p2c_valid = v.mv; p2c_is_dn = v.mdn; p2c_addr = v.ma; p2c_state = v.mst; p2c_data = v.md;
         dnr_ready = v.drdy;
         #1;
         ok = (rsp_valid == v.e_rsp) && (!v.e_rsp || (rsp_data == v.e_rdata && rsp_tag == v.ptag))
              && (upq_valid == v.e_upq) && (!v.e_upq || (upq_state == v.e_upst && upq_addr == v.pa))
              && (dnr_valid == v.e_dnr) && (!v.e_dnr || (dnr_state == v.e_dnst && dnr_data == v.e_dndata && dnr_addr == v.ma))
              && (p2c_pop == v.e_pop) && !ev_done;
         check(ok, $sformatf("%s row %0d", row_req(i), i),
               64'({rsp_valid, rsp_data, rsp_tag, upq_valid, upq_state, dnr_valid, dnr_state, dnr_data, p2c_pop}),
               64'({v.e_rsp, v.e_rdata, v.ptag, v.e_upq, v.e_upst, v.e_dnr, v.e_dnst, v.e_dndata, v.e_pop}));
      end

      // R10: eviction loses to a parent upgrade response (line 2 to M, data AB)
      @(negedge clk);
      idle_inputs();
      ev_valid = 1; ev_addr = 1; ev_state = 1;
      p2c_valid = 1; p2c_is_dn = 0; p2c_addr = 2; p2c_state = 2; p2c_data = 8'hAB;
      #1;
      check(p2c_pop && !ev_done && !dnr_valid, "R10 evict blocked",
            64'({p2c_pop, ev_done, dnr_valid}), 64'b100);

      // R9: line 1 is M with data 11, evict to S
      @(negedge clk);
      idle_inputs();
      ev_valid = 1; ev_addr = 1; ev_state = 1;
      #1;
      check(ev_done && dnr_valid && dnr_state == 2'd1 && dnr_data == 8'h11 && dnr_addr == 2'd1,
            "R9 evict", 64'({ev_done, dnr_valid, dnr_state, dnr_data}), 64'({1'b1, 1'b1, 2'd1, 8'h11}));

      // R9: second evict to S has nothing to do
      @(negedge clk);
      #1;
      check(ev_done && !dnr_valid, "R9 evict noop", 64'({ev_done, dnr_valid}), 64'b10);

      // R3: line 2 now M, store CD then load it back
      @(negedge clk);
      idle_inputs();
      req_valid = 1; req_is_store = 1; req_addr = 2; req_wdata = 8'hCD; req_tag = 8;
      #1;
      check(rsp_valid && rsp_tag == 4'd8 && rsp_data == 8'hCD && !upq_valid, "R3 store M",
            64'({rsp_valid, rsp_tag, rsp_data, upq_valid}), 64'({1'b1, 4'd8, 8'hCD, 1'b0}));
      @(negedge clk);
      req_is_store = 0; req_tag = 1;
      #1;
      check(rsp_valid && rsp_data == 8'hCD && rsp_tag == 4'd1, "R3 readback",
            64'({rsp_valid, rsp_data}), 64'({1'b1, 8'hCD}));

      // R1: reset returns every line to Invalid with no pending upgrade
      @(negedge clk);
      idle_inputs();
      rst_n = 0;
      @(negedge clk);
      rst_n = 1;
      req_valid = 1; req_addr = 2; req_tag = 3;
      #1;
      check(!rsp_valid && upq_valid && upq_state == 2'd1 && upq_addr == 2'd2, "R1 line invalid",
            64'({rsp_valid, upq_valid, upq_state}), 64'({1'b0, 1'b1, 2'd1}));

      @(negedge clk);
      idle_inputs();
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule